// File: doc/BRIEF.md
# Shadowed BCD Calendar Clock Register File

This block keeps a calendar clock (seconds, minutes, hours, weekday, day of month, month and two-digit year) in internal BCD counters. A one-pulse-per-second tick input moves the counters forward. The host never sees the counters directly. It sees eight byte registers at the top of its address space: one control byte and seven time bytes. The time bytes are a shadow copy that is refreshed from the counters after every count step.

The host uses a simple synchronous register port: address, write enable, write data, and a combinational read-data output. Two control bits manage the shadow. The freeze bit holds the shadow steady so that a multi-byte read stays consistent. The load bit holds the shadow so that the host can write a new time, and clearing it copies the shadow into the counters. A stop bit in the seconds byte halts counting.

Top module: `rtc_shadow_regfile`

## Requirements
- R1: Only addresses whose upper ADDR_W-3 bits are all ones are mapped. Offset 0 is control, and offsets 1 to 7 are seconds, minutes, hours, weekday, day of month, month and year. Unmapped addresses read 0x00 and writes to them have no effect. Control bits 5:0 read 0. Each time byte keeps only its field width (seconds 7, minutes 7, hours 6, weekday 3, day of month 6, month 5, year 8 bits).
- R2: After reset, the control byte reads 0x00, STOP is 0, and the time reads 00:00:00 with weekday 1, day 01, month 01 and year 00. A reset that follows a write of 0xC0 to control clears both control bits again.
- R3: Each tick with STOP at 0 adds one BCD second. A wrap of seconds at 59 carries into minutes, minutes at 59 carry into hours, and hours at 23 carry into both the weekday (which runs 1 to 7, then back to 1) and the day of month.
- R4: The day of month wraps to 01 after the last day of its month: 31, 30 for months 04, 06, 09 and 11, and for month 02 either 29 when the year is divisible by 4 or 28 otherwise. That wrap carries into the month, month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R5: All seven shadow bytes take the new counter value on the same clock edge, one cycle after the edge that sampled the tick. They still show the old time during the cycle in between.
- R6: While control bit 6 (freeze) is 1, the shadow does not change on ticks, but the counters keep running. After the bit is cleared, the shadow still holds the frozen value until the next tick shows the current count.
- R7: While control bit 7 (load) is 1, the shadow does not change on ticks, and host writes to time bytes persist. Writing control with bit 7 at 0 while it was 1 copies the shadow into the counters on that clock edge.
- R8: A write to a time byte while bit 7 is 0 changes only the shadow byte. The next refresh replaces it with the counter value, and the counters are not affected.
- R9: Bit 7 of the seconds byte is STOP. A write to the seconds byte sets or clears it at once, whatever the control bits are. While STOP is 1, ticks neither advance the counters nor refresh the shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| reg_addr_i | input | ADDR_W | Register address |
| reg_we_i | input | 1 | Write enable |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |

## Verification
The bench steps a model calendar through more than an hour of ticks from reset. It also loads the last two days of every month across leap, non-leap and century-end years, which catches a wrong February length, a 30/31 mix-up, or a year that does not wrap from 99 to 00. Separate scenarios cover the freeze, load and stop bits. A design that refreshed the shadow while frozen would show moving time. A design that dropped the commit would resume from the old count. A design that let STOP wait for the load sequence would keep counting. One tick is sampled cycle by cycle, so a refresh that lands one cycle early or late shows up as a wrong byte.

// File: rtl/rtc_pkg.sv
// Package: shared types and BCD/calendar helper functions for the shadowed
// calendar clock. Assumes two-digit BCD fields held in bytes.
package rtc_pkg;
    localparam int NUM_FIELDS = 7;
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HR   = 2;
    localparam int F_DAY  = 3;
    localparam int F_DATE = 4;
    localparam int F_MON  = 5;
    localparam int F_YR   = 6;

    typedef logic [7:0] bcd8_t;
    typedef logic [NUM_FIELDS*8-1:0] time_vec_t;

    // Bits a field keeps; the rest read as zero.
    function automatic bcd8_t field_mask(int idx);
        case (idx)
            F_SEC, F_MIN: return 8'h7F;
            F_HR, F_DATE: return 8'h3F;
            F_DAY:        return 8'h07;
            F_MON:        return 8'h1F;
            default:      return 8'hFF;
        endcase
    endfunction

    // Value a field restarts from after wrapping, also its reset value.
    function automatic bcd8_t field_low(int idx);
        case (idx)
            F_DAY, F_DATE, F_MON: return 8'h01;
            default:              return 8'h00;
        endcase
    endfunction

    // Last value of a field with a fixed range (day of month is dynamic).
    function automatic bcd8_t field_high_fixed(int idx);
        case (idx)
            F_SEC, F_MIN: return 8'h59;
            F_HR:         return 8'h23;
            F_DAY:        return 8'h07;
            F_MON:        return 8'h12;
            F_DATE:       return 8'h31;
            default:      return 8'h99;
        endcase
    endfunction

    // Field whose wrap drives this field's step: day of month follows hours.
    function automatic int carry_src(int idx);
        if (idx == F_DATE) return F_HR;
        return idx - 1;
    endfunction

    // Two-digit BCD increment without range limit.
    function automatic bcd8_t bcd_inc(bcd8_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Year divisible by four, evaluated on the BCD digits.
    function automatic logic bcd_leap(bcd8_t y);
        if (y[4] == 1'b0) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    // Last day of the month in BCD.
    function automatic bcd8_t month_last(bcd8_t mon, bcd8_t yr);
        case (mon)
            8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_bcd_wrap.sv
// Module: one BCD field counter that either loads a value, steps with wrap
// from hi_i to lo_i, or holds. Assumes the limits are valid BCD.
module rtc_bcd_wrap #(
    parameter logic [7:0] RST_VAL = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_i,
    input  logic       load_i,
    input  logic [7:0] load_val_i,
    input  logic [7:0] lo_i,
    input  logic [7:0] hi_i,
    output logic [7:0] val_o,
    output logic       wrap_o
);
    logic [7:0] val_q;

    // Wrap event feeds the next field's step.
    assign wrap_o = step_i && (val_q == hi_i);
    assign val_o  = val_q;

    // Field register: load has priority over stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= RST_VAL;
        end else if (load_i) begin
            val_q <= load_val_i;
        end else if (step_i) begin
            val_q <= (val_q == hi_i) ? lo_i : rtc_pkg::bcd_inc(val_q);
        end
    end
endmodule

// File: rtl/rtc_calendar.sv
// Module: the real calendar counters. Seven BCD fields chained by carries;
// the day-of-month limit follows month and leap year. Assumes adv_i is at
// most one pulse per count and load_i carries a complete time vector.
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv_i,
    input  logic      load_i,
    input  time_vec_t load_vec_i,
    output time_vec_t cnt_vec_o
);
    logic [NUM_FIELDS-1:0] step;
    logic [NUM_FIELDS-1:0] wrap;
    bcd8_t                 cnt [NUM_FIELDS];
    logic                  unused_wraps;

    // Weekday and year wraps drive nothing further.
    assign unused_wraps = wrap[F_DAY] ^ wrap[F_YR];

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        bcd8_t hi;
        if (i == 0) begin : g_first
            assign step[i] = adv_i;
        end else begin : g_chain
            assign step[i] = wrap[carry_src(i)];
        end
        if (i == F_DATE) begin : g_dyn
            assign hi = month_last(cnt[F_MON], cnt[F_YR]);
        end else begin : g_fix
            assign hi = field_high_fixed(i);
        end
        rtc_bcd_wrap #(.RST_VAL(field_low(i))) u_fld (
            .clk        (clk),
            .rst_n      (rst_n),
            .step_i     (step[i]),
            .load_i     (load_i),
            .load_val_i (load_vec_i[i*8 +: 8]),
            .lo_i       (field_low(i)),
            .hi_i       (hi),
            .val_o      (cnt[i]),
            .wrap_o     (wrap[i])
        );
        assign cnt_vec_o[i*8 +: 8] = cnt[i];
    end
endmodule

// File: rtl/rtc_host_regs.sv
// Module: host-visible register window. Holds control, STOP and the time
// shadow; decodes writes, refreshes the shadow and raises the commit pulse.
// Assumes ADDR_W >= 4 and a combinational read path.
module rtc_host_regs
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    input  time_vec_t         cnt_vec_i,
    input  logic              adv_done_i,
    output time_vec_t         shd_vec_o,
    output logic              stop_o,
    output logic              load_o,
    output logic              freeze_o,
    output logic              hold_o,
    output logic              refresh_o,
    output logic              time_wr_o
);
    localparam int OFF_W = 3;

    logic                  hit;
    logic [OFF_W-1:0]      off;
    logic                  wr_ctl;
    logic [NUM_FIELDS-1:0] wr_fld;
    logic                  freeze_q;
    logic                  hold_q;
    logic                  stop_q;
    bcd8_t                 shd [NUM_FIELDS];

    // Address decode into the top eight locations.
    assign hit    = &addr_i[ADDR_W-1:OFF_W];
    assign off    = addr_i[OFF_W-1:0];
    assign wr_ctl = we_i && hit && (off == '0);

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
        assign wr_fld[i] = we_i && hit && (off == OFF_W'(i + 1));
    end

    // Shadow follows the counters only when neither control bit holds it.
    assign refresh_o = adv_done_i && !freeze_q && !hold_q;
    // Commit when the load bit goes from 1 to 0 by a host write.
    assign load_o    = wr_ctl && hold_q && !wdata_i[7];
    assign time_wr_o = |wr_fld;
    assign stop_o    = stop_q;
    assign freeze_o  = freeze_q;
    assign hold_o    = hold_q;

    // Control bits: freeze (6) and load (7).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freeze_q <= 1'b0;
            hold_q   <= 1'b0;
        end else if (wr_ctl) begin
            freeze_q <= wdata_i[6];
            hold_q   <= wdata_i[7];
        end
    end

    // STOP bit: live on every seconds-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
        end else if (wr_fld[F_SEC]) begin
            stop_q <= wdata_i[7];
        end
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_shd
        bcd8_t val_q;
        // Shadow byte: refresh wins over a host write in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= field_low(i);
            end else if (refresh_o) begin
                val_q <= cnt_vec_i[i*8 +: 8];
            end else if (wr_fld[i]) begin
                val_q <= wdata_i & field_mask(i);
            end
        end
        assign shd[i] = val_q;
        assign shd_vec_o[i*8 +: 8] = val_q;
    end

    // Read mux for the register window.
    always_comb begin
        rdata_o = 8'h00;
        if (hit) begin
            case (off)
                3'd0:    rdata_o = {hold_q, freeze_q, 6'b0};
                3'd1:    rdata_o = {stop_q, shd[F_SEC][6:0]};
                default: rdata_o = shd[off - 3'd1];
            endcase
        end
    end
endmodule

// File: rtl/rtc_shadow_regfile.sv
// Module (top): calendar counters behind a shadow register window. A tick
// qualified by STOP advances the counters; the next cycle refreshes the
// shadow unless the host holds it. Assumes tick_i is a one-cycle pulse.
module rtc_shadow_regfile
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_we_i,
    input  logic [7:0]        reg_wdata_i,
    output logic [7:0]        reg_rdata_o
);
    logic      adv;
    logic      adv_q;
    logic      stop_q;
    logic      cnt_load;
    logic      ctl_rd;
    logic      ctl_wr;
    logic      refresh;
    logic      time_wr;
    time_vec_t cnt_flat;
    time_vec_t shd_flat;

    assign adv = tick_i && !stop_q;

    // Remembers a count step so the shadow refreshes one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) adv_q <= 1'b0;
        else        adv_q <= adv;
    end

    rtc_calendar u_cal (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (adv),
        .load_i     (cnt_load),
        .load_vec_i (shd_flat),
        .cnt_vec_o  (cnt_flat)
    );

    rtc_host_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (reg_addr_i),
        .we_i       (reg_we_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .cnt_vec_i  (cnt_flat),
        .adv_done_i (adv_q),
        .shd_vec_o  (shd_flat),
        .stop_o     (stop_q),
        .load_o     (cnt_load),
        .freeze_o   (ctl_rd),
        .hold_o     (ctl_wr),
        .refresh_o  (refresh),
        .time_wr_o  (time_wr)
    );
endmodule

// File: rtl/rtc_shadow_regfile_chk.sv
// Checker: temporal properties between counters, shadow and control.
// Bound into the top module; observes only.
module rtc_shadow_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_i,
    input logic        stop_q,
    input logic        cnt_load,
    input logic [55:0] cnt_flat,
    input logic [55:0] shd_flat,
    input logic        ctl_rd,
    input logic        ctl_wr,
    input logic        refresh,
    input logic        time_wr
);
    logic past_rst_low = 1'b0;

    // Control bits must be clear on the edge after a reset cycle.
    always_ff @(posedge clk) begin
        past_rst_low <= !rst_n;
        if (past_rst_low) begin
            AST_RESET_CTL: assert (!ctl_rd && !ctl_wr) else $error("control not cleared"); // R2
        end
    end

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !stop_q && !cnt_load) |=> (cnt_flat != $past(cnt_flat))); // R3
    AST_REFRESH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (shd_flat == $past(cnt_flat))); // R5
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_rd || ctl_wr) && !time_wr) |=> $stable(shd_flat)); // R6
    AST_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctl_wr) && $past(rst_n)) |-> (cnt_flat == $past(shd_flat))); // R7
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !cnt_load) |=> $stable(cnt_flat)); // R9
endmodule

bind rtc_shadow_regfile rtc_shadow_regfile_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .stop_q   (stop_q),
    .cnt_load (cnt_load),
    .cnt_flat (cnt_flat),
    .shd_flat (shd_flat),
    .ctl_rd   (ctl_rd),
    .ctl_wr   (ctl_wr),
    .refresh  (refresh),
    .time_wr  (time_wr)
);

// File: tb/rtc_shadow_regfile_bench.sv
module rtc_shadow_regfile_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 13;
    localparam int BASE       = (1 << ADDR_W) - 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              we = 1'b0;
    logic [7:0]        wdata = '0;
    logic [7:0]        rdata;

    rtc_shadow_regfile #(.ADDR_W(ADDR_W)) u_rtc_shadow_regfile (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_addr_i(addr),
        .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int m_s, m_mi, m_h, m_d, m_dt, m_mo, m_y;

    function automatic int tobcd(int v);
        return ((v / 10) * 16) + (v % 10);
    endfunction

    function automatic int dim(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [55:0] pack_model();
        return {8'(tobcd(m_y)), 8'(tobcd(m_mo)), 8'(tobcd(m_dt)), 8'(tobcd(m_d)),
                8'(tobcd(m_h)), 8'(tobcd(m_mi)), 8'(tobcd(m_s))};
    endfunction

    task automatic model_reset();
        m_s = 0; m_mi = 0; m_h = 0; m_d = 1; m_dt = 1; m_mo = 1; m_y = 0;
    endtask

    task automatic model_step();
        m_s++;
        if (m_s == 60) begin
            m_s = 0; m_mi++;
            if (m_mi == 60) begin
                m_mi = 0; m_h++;
                if (m_h == 24) begin
                    m_h = 0;
                    m_d = (m_d == 7) ? 1 : m_d + 1;
                    m_dt++;
                    if (m_dt > dim(m_mo, m_y)) begin
                        m_dt = 1; m_mo++;
                        if (m_mo == 13) begin
                            m_mo = 1; m_y = (m_y + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic check(string req, logic [55:0] act, logic [55:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd_abs(int a, output logic [7:0] v);
        @(negedge clk);
        addr = ADDR_W'(a); we = 1'b0;
        #1 v = rdata;
    endtask

    task automatic rd(int off, output logic [7:0] v);
        rd_abs(BASE + off, v);
    endtask

    task automatic wr_abs(int a, int v);
        @(negedge clk);
        addr = ADDR_W'(a); wdata = 8'(v); we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic wr(int off, int v);
        wr_abs(BASE + off, v);
    endtask

    task automatic tick_n(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic read_time(output logic [55:0] t);
        logic [7:0] b;
        for (int i = 0; i < 7; i++) begin
            rd(i + 1, b);
            if (i == 0) b = b & 8'h7F;
            t[i*8 +: 8] = b;
        end
    endtask

    task automatic expect_time(string req);
        logic [55:0] t;
        read_time(t);
        check(req, t, pack_model());
    endtask

    task automatic set_time(int h, int mi, int s, int d, int dt, int mo, int y);
        wr(0, 8'h80);
        wr(1, tobcd(s)); wr(2, tobcd(mi)); wr(3, tobcd(h)); wr(4, tobcd(d));
        wr(5, tobcd(dt)); wr(6, tobcd(mo)); wr(7, tobcd(y));
        wr(0, 8'h00);
        m_s = s; m_mi = mi; m_h = h; m_d = d; m_dt = dt; m_mo = mo; m_y = y;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        for (int c = 0; c < 190000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [55:0] snap;
        logic [55:0] t;
        int yrs [7] = '{0, 1, 4, 23, 24, 96, 99};

        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        model_reset();

        // R2: reset state
        rd(0, b); check("R2 ctl", 56'(b), 56'h00);
        expect_time("R2 time");

        // R1: unmapped space and unused control bits
        wr_abs(5, 8'hFF); rd_abs(5, b); check("R1 unmapped", 56'(b), 56'h00);
        wr(0, 8'h3F); rd(0, b); check("R1 ctl low bits", 56'(b), 56'h00);

        // R3: long run from reset, covering minute and hour carries
        for (int k = 0; k < 3700; k++) begin
            tick_n(1); model_step();
            expect_time("R3 run");
        end
        // R3: weekday wraps 7 -> 1 with a date carry
        set_time(23, 59, 59, 7, 10, 5, 21);
        tick_n(1); model_step(); expect_time("R3 weekday wrap");

        // R4: last two days of every month over several years
        foreach (yrs[j]) begin
            for (int mo = 1; mo <= 12; mo++) begin
                for (int back = 1; back >= 0; back--) begin
                    set_time(23, 59, 59, 3, dim(mo, yrs[j]) - back, mo, yrs[j]);
                    tick_n(1); model_step(); expect_time("R4 month end");
                end
            end
        end

        // R5: shadow changes exactly one cycle after the tick edge
        set_time(12, 0, 5, 2, 15, 6, 30);
        tick_n(1); model_step(); snap = pack_model();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0; addr = ADDR_W'(BASE + 1); #1;
        check("R5 before refresh", 56'(rdata & 8'h7F), 56'(tobcd(m_s)));
        model_step();
        @(negedge clk); #1;
        check("R5 after refresh", 56'(rdata & 8'h7F), 56'(tobcd(m_s)));
        expect_time("R5 all bytes");

        // R6: freeze holds shadow while counters keep running
        wr(0, 8'h40); snap = pack_model();
        tick_n(3); model_step(); model_step(); model_step();
        read_time(t); check("R6 frozen", t, snap);
        wr(0, 8'h00);
        read_time(t); check("R6 until next tick", t, snap);
        tick_n(1); model_step(); expect_time("R6 resumed");

        // R7: load bit, host writes persist, commit on clear
        wr(0, 8'h80); rd(0, b); check("R7 ctl", 56'(b), 56'h80);
        snap = pack_model();
        tick_n(2);
        read_time(t); check("R7 held", t, snap);
        wr(3, 8'hFF); rd(3, b); check("R1 hours mask", 56'(b), 56'h3F);
        wr(1, 8'h07); wr(2, 8'h06); wr(3, 8'h05); wr(4, 8'h02);
        wr(5, 8'h15); wr(6, 8'h08); wr(7, 8'h30);
        tick_n(1);
        m_s = 7; m_mi = 6; m_h = 5; m_d = 2; m_dt = 15; m_mo = 8; m_y = 30;
        expect_time("R7 written");
        wr(0, 8'h00);
        tick_n(1); model_step(); expect_time("R7 committed");

        // R8: shadow-only write overwritten at next refresh
        wr(2, 8'h33); rd(2, b); check("R8 shadow write", 56'(b), 56'h33);
        tick_n(1); model_step(); expect_time("R8 replaced");

        // R9: STOP halts counting without the load sequence
        wr(1, 8'h80 | tobcd(m_s)); rd(1, b);
        check("R9 stop bit", 56'(b), 56'(8'h80 | tobcd(m_s)));
        tick_n(3); expect_time("R9 stopped");
        wr(1, tobcd(m_s));
        tick_n(1); model_step(); expect_time("R9 restarted");

        // R2: reset clears freeze and load
        wr(0, 8'hC0); rd(0, b); check("R2 ctl set", 56'(b), 56'hC0);
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; model_reset();
        rd(0, b); check("R2 ctl after reset", 56'(b), 56'h00);
        expect_time("R2 time after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule